// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Recorder

This block is a software-visible watchdog. An up-counter advances once for each cycle in which the `tick` input is high. Software can read the counter and reload it at any time. When the counter rolls over from its all-ones value to zero, a sticky overflow flag is set. If the interrupt enable is set, the flag drives an interrupt line. If the reset enable is set, the same overflow produces a one-cycle system reset request.

The enable bits and the software reset bit sit behind a lock. They change only when the `unlock` input is high during the write. That input stands in for the unlock sequence on the bus, which is modelled outside this block. Every write to the control register must also carry the key value 01b in bits 7:6, or the write is dropped. Clearing the flag does not require the lock to be open.

A small recorder keeps the cause of the most recent reset. Only the power-on reset clears it. It therefore survives the system reset that the watchdog itself requests, and boot software can read it afterwards.

Top module: `wdt_sentinel`

## Requirements
- R1: After `sys_rst_n` and `por_n` are released, the block is in its idle state:
  - address 0x03 (counter) reads 0x00;
  - address 0x06 (control) reads 0x00;
  - address 0x05 (cause) reads 0x01, the power-on code;
  - `irq` and `rst_req` are low.
- R2: The counter increments by one on each clock edge that sees `tick` high. Reading address 0x03 returns its value. Writing address 0x03 loads the write data. A load overrides a tick in the same cycle.
- R3: A tick while the counter holds 0xFF wraps it to 0x00 and sets the overflow flag, which reads back in control bit 3. The flag stays set through further ticks until it is cleared.
- R4: A control write with a valid key and bit 3 set clears the flag, whatever the state of `unlock`. A write with bit 3 at 0 leaves the flag unchanged. If an overflow happens in the same cycle as a clear, the flag stays set.
- R5: `irq` is high exactly when the flag is set and the interrupt enable is set. The interrupt enable is control bit 2.
- R6: The reset enable is control bit 1. With it set, an overflow drives `rst_req` high for exactly one cycle, visible after the wrapping edge, and records cause code 2. With it clear, an overflow produces no request and leaves the recorded cause unchanged.
- R7: Control bits 2:1 (the enables) and bit 0 (software reset) take effect only when `unlock` is high during a valid-key write. Otherwise the enables are unchanged and no reset is requested.
- R8: A control write whose bits 7:6 are not 01b is ignored completely. It changes no enable and does not clear the flag.
- R9: An unlocked valid-key control write with bit 0 set produces a one-cycle `rst_req` and records cause code 0. Bit 0 always reads back as 0.
- R10: A one-cycle pulse on `pin_rst` records cause code 3. When events coincide, the recorded code follows the priority pin (3), then watchdog (2), then software (0).
- R11: `sys_rst_n` returns the counter, enables and flag to their reset values but keeps the recorded cause. Only `por_n` sets the cause back to code 1. Reads of any unused address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears the cause recorder |
| sys_rst_n | input | 1 | System reset, asynchronous, active low; clears counter, enables and flag |
| tick | input | 1 | Count enable, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| unlock | input | 1 | Lock open; allows enable and software-reset changes |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| pin_rst | input | 1 | External reset event pulse, for cause capture |
| irq | output | 1 | Overflow interrupt |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A corrupted counter shows up at the ports in two ways. Reading 0x03 exposes it at once. It also moves the overflow: the flag, `irq` and `rst_req` appear on the wrong tick, so a preloaded value of 0xFE followed by exactly two ticks pins the wrap to a known edge. A lost or stuck enable or flag is visible in the very next read of 0x06, and also on `irq`, one edge after the write that should have changed it. A wrong recorded cause stays hidden until address 0x05 is read. The bench therefore reads it straight after every reset event, including coinciding ones, and after a system reset that must leave it untouched.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Codes held by the reset-cause recorder
   typedef enum logic [1:0] {
      CAUSE_SOFT  = 2'd0,
      CAUSE_POWER = 2'd1,
      CAUSE_WDOG  = 2'd2,
      CAUSE_PIN   = 2'd3
   } cause_e;

   // Control register layout
   localparam int unsigned SWRST_BIT = 0;
   localparam int unsigned RSTEN_BIT = 1;
   localparam int unsigned INTEN_BIT = 2;
   localparam int unsigned FLAG_BIT  = 3;
   localparam int unsigned KEY_LSB   = 6;
   localparam logic [1:0]  CTRL_KEY  = 2'b01;

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   // a load takes priority, so a wrap can only come from a plain tick
   assign wrap = tick && !load && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (tick) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
   import wdt_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              unlock,
   input  logic              wrap,
   output logic              rst_en_q,
   output logic              int_en_q,
   output logic              flag_q,
   output logic              irq,
   output logic              wdog_evt,
   output logic              sw_evt
);

   logic key_ok;
   logic prot_wr;

   assign key_ok  = wr && (wr_data[KEY_LSB +: 2] == CTRL_KEY);
   assign prot_wr = key_ok && unlock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_en_q <= 1'b0;
         int_en_q <= 1'b0;
      end else if (prot_wr) begin
         rst_en_q <= wr_data[RSTEN_BIT];
         int_en_q <= wr_data[INTEN_BIT];
      end
   end

   // setting by overflow wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (wrap) begin
         flag_q <= 1'b1;
      end else if (key_ok && wr_data[FLAG_BIT]) begin
         flag_q <= 1'b0;
      end
   end

   assign wdog_evt = wrap && rst_en_q;
   assign sw_evt   = prot_wr && wr_data[SWRST_BIT];

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= flag_q && int_en_q;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = flag_q && int_en_q;
      end
   endgenerate

endmodule

// File: rtl/wdt_cause.sv
module wdt_cause
   import wdt_pkg::*;
(
   input  logic   clk,
   input  logic   por_n,
   input  logic   pin_evt,
   input  logic   wdog_evt,
   input  logic   sw_evt,
   output cause_e cause_q,
   output logic   rst_req_q
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cause_q <= CAUSE_POWER;
      end else if (pin_evt) begin
         cause_q <= CAUSE_PIN;
      end else if (wdog_evt) begin
         cause_q <= CAUSE_WDOG;
      end else if (sw_evt) begin
         cause_q <= CAUSE_SOFT;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rst_req_q <= 1'b0;
      end else begin
         rst_req_q <= wdog_evt || sw_evt;
      end
   end

endmodule

// File: rtl/wdt_sentinel.sv
module wdt_sentinel
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_ADDR  = 3,
   parameter int unsigned STAT_ADDR = 5,
   parameter int unsigned CTRL_ADDR = 6,
   parameter bit          IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              unlock,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pin_rst,
   output logic              irq,
   output logic              rst_req
);

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(CNT_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   initial begin
      if (DATA_W != 8) $error("wdt_sentinel: DATA_W must be 8");
      if (CNT_W < 2 || CNT_W > DATA_W) $error("wdt_sentinel: CNT_W out of range");
      if ((CNT_ADDR >= (1 << ADDR_W)) || (STAT_ADDR >= (1 << ADDR_W)) ||
          (CTRL_ADDR >= (1 << ADDR_W)))
         $error("wdt_sentinel: address outside ADDR_W");
      if (CNT_ADDR == STAT_ADDR || CNT_ADDR == CTRL_ADDR || STAT_ADDR == CTRL_ADDR)
         $error("wdt_sentinel: register addresses overlap");
   end

   logic             cnt_wr;
   logic             ctrl_wr;
   logic [CNT_W-1:0] cnt_q;
   logic             wrap;
   logic             rst_en_q;
   logic             int_en_q;
   logic             flag_q;
   logic             wdog_evt;
   logic             sw_evt;
   cause_e           cause_q;

   assign cnt_wr  = wr_en && (wr_addr == A_CNT);
   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   wdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .tick     (tick),
      .load     (cnt_wr),
      .load_val (wr_data[CNT_W-1:0]),
      .cnt_q    (cnt_q),
      .wrap     (wrap)
   );

   wdt_ctrl #(
      .DATA_W  (DATA_W),
      .IRQ_REG (IRQ_REG)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (sys_rst_n),
      .wr       (ctrl_wr),
      .wr_data  (wr_data),
      .unlock   (unlock),
      .wrap     (wrap),
      .rst_en_q (rst_en_q),
      .int_en_q (int_en_q),
      .flag_q   (flag_q),
      .irq      (irq),
      .wdog_evt (wdog_evt),
      .sw_evt   (sw_evt)
   );

   wdt_cause u_cause (
      .clk       (clk),
      .por_n     (por_n),
      .pin_evt   (pin_rst),
      .wdog_evt  (wdog_evt),
      .sw_evt    (sw_evt),
      .cause_q   (cause_q),
      .rst_req_q (rst_req)
   );

   logic [DATA_W-1:0] ctrl_view;
   always_comb begin
      ctrl_view            = '0;
      ctrl_view[RSTEN_BIT] = rst_en_q;
      ctrl_view[INTEN_BIT] = int_en_q;
      ctrl_view[FLAG_BIT]  = flag_q;
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CNT) begin
         rd_data[CNT_W-1:0] = cnt_q;
      end else if (rd_addr == A_CTRL) begin
         rd_data = ctrl_view;
      end else if (rd_addr == A_STAT) begin
         rd_data[1:0] = cause_q;
      end
   end

endmodule

// File: rtl/wdt_sentinel_chk.sv
module wdt_sentinel_chk
   import wdt_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned CNT_ADDR  = 3,
   parameter int unsigned CTRL_ADDR = 6
) (
   input logic              clk,
   input logic              por_n,
   input logic              sys_rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              unlock,
   input logic              pin_rst,
   input logic [CNT_W-1:0]  cnt_q,
   input logic              wrap,
   input logic              flag_q,
   input logic              rst_en_q,
   input logic              int_en_q,
   input logic              rst_req,
   input cause_e            cause_q
);

   logic ctrl_w;
   logic key_good;
   logic cnt_w;

   assign ctrl_w   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
   assign cnt_w    = wr_en && (wr_addr == ADDR_W'(CNT_ADDR));
   assign key_good = (wr_data[KEY_LSB +: 2] == CTRL_KEY);

   // R2
   cnt_load_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      cnt_w |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

   // R3
   wrap_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      wrap |=> (flag_q && (cnt_q == '0)));

   // R7
   locked_en_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      (ctrl_w && !unlock) |=> ($stable(rst_en_q) && $stable(int_en_q)));

   // R8
   bad_key_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      (ctrl_w && !key_good && !wrap) |=> ($stable(rst_en_q) && $stable(int_en_q) && $stable(flag_q)));

   // R4
   flag_clear_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      (ctrl_w && key_good && wr_data[FLAG_BIT] && !wrap) |=> !flag_q);

   // R6
   wdog_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      (wrap && rst_en_q && !pin_rst) |=> (rst_req && (cause_q == CAUSE_WDOG)));

   // R9
   sw_req_chk: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_n)
      (ctrl_w && key_good && unlock && wr_data[SWRST_BIT]) |=> rst_req);

endmodule

bind wdt_sentinel wdt_sentinel_chk #(
   .CNT_W     (CNT_W),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .CNT_ADDR  (CNT_ADDR),
   .CTRL_ADDR (CTRL_ADDR)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .sys_rst_n (sys_rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .unlock    (unlock),
   .pin_rst   (pin_rst),
   .cnt_q     (cnt_q),
   .wrap      (wrap),
   .flag_q    (flag_q),
   .rst_en_q  (rst_en_q),
   .int_en_q  (int_en_q),
   .rst_req   (rst_req),
   .cause_q   (cause_q)
);

// File: tb/test_wdt_sentinel.sv
module test_wdt_sentinel;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       unlock = 1'b0;
   logic [3:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       pin_rst = 1'b0;
   logic       irq;
   logic       rst_req;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   wdt_sentinel i_wdt_sentinel (
      .clk       (clk),
      .por_n     (por_n),
      .sys_rst_n (sys_rst_n),
      .tick      (tick),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .unlock    (unlock),
      .rd_addr   (rd_addr),
      .rd_data   (rd_data),
      .pin_rst   (pin_rst),
      .irq       (irq),
      .rst_req   (rst_req)
   );

   // row: {unlock, wr_addr, wr_data, read addr, expected read}
   localparam int NV = 8;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 4'h6, 8'h46, 4'h6, 8'h06},  // R7 unlocked enable write
      {1'b0, 4'h6, 8'h40, 4'h6, 8'h06},  // R7 locked write keeps enables
      {1'b1, 4'h6, 8'h00, 4'h6, 8'h06},  // R8 key 00 ignored
      {1'b1, 4'h6, 8'h44, 4'h6, 8'h04},  // R5 interrupt enable only
      {1'b0, 4'h3, 8'h5A, 4'h3, 8'h5A},  // R2 counter load
      {1'b0, 4'h3, 8'hFF, 4'h3, 8'hFF},  // R2 counter load all ones
      {1'b1, 4'h6, 8'hC2, 4'h6, 8'h04},  // R8 key 11 ignored
      {1'b1, 4'h6, 8'h40, 4'h6, 8'h00}   // R7 enables cleared
   };

   function automatic string row_req(input int r);
      case (r)
         0, 1, 7: return "R7";
         2, 6:    return "R8";
         3:       return "R5";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   // caller sits at a falling edge; returns at the falling edge after one rising edge
   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic ul, input logic tk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; unlock = ul; tick = tk;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; unlock = 1'b0; tick = 1'b0;
   endtask

   task automatic tick_n(input int n);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic finish_run();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);

      // R1 idle state
      rdchk("R1", 4'h3, 8'h00);
      rdchk("R1", 4'h6, 8'h00);
      rdchk("R1", 4'h5, 8'h01);
      chk("R1", {7'd0, irq}, 8'h00);
      chk("R1", {7'd0, rst_req}, 8'h00);

      for (int r = 0; r < NV; r++) begin
         wr(VEC[r][23:20], VEC[r][19:12], VEC[r][24], 1'b0);
         rdchk(row_req(r), VEC[r][11:8], VEC[r][7:0]);
      end

      // R2 counting and load over tick
      wr(4'h3, 8'h10, 1'b0, 1'b0);
      tick_n(3);
      rdchk("R2", 4'h3, 8'h13);
      wr(4'h3, 8'h20, 1'b0, 1'b1);
      rdchk("R2", 4'h3, 8'h20);
      rdchk("R11", 4'h9, 8'h00);

      // R3 R5 R6 overflow with both enables
      wr(4'h6, 8'h46, 1'b1, 1'b0);
      wr(4'h3, 8'hFE, 1'b0, 1'b0);
      tick_n(2);
      chk("R6", {7'd0, rst_req}, 8'h01);
      chk("R5", {7'd0, irq}, 8'h01);
      rdchk("R3", 4'h3, 8'h00);
      rdchk("R3", 4'h6, 8'h0E);
      rdchk("R6", 4'h5, 8'h02);
      @(negedge clk);
      chk("R6", {7'd0, rst_req}, 8'h00);
      tick_n(1);
      rdchk("R3", 4'h6, 8'h0E);

      // R4 clear behaviour
      wr(4'h6, 8'h46, 1'b1, 1'b0);
      rdchk("R4", 4'h6, 8'h0E);
      wr(4'h6, 8'h4E, 1'b0, 1'b0);
      rdchk("R4", 4'h6, 8'h06);
      chk("R5", {7'd0, irq}, 8'h00);

      // R8 bad key does not clear the flag
      wr(4'h3, 8'hFF, 1'b0, 1'b0);
      tick_n(1);
      wr(4'h6, 8'h0E, 1'b1, 1'b0);
      rdchk("R8", 4'h6, 8'h0E);

      // R4 overflow wins over a clear in the same cycle
      wr(4'h6, 8'h4E, 1'b0, 1'b0);
      wr(4'h3, 8'hFF, 1'b0, 1'b0);
      wr(4'h6, 8'h4E, 1'b0, 1'b1);
      rdchk("R4", 4'h6, 8'h0E);
      wr(4'h6, 8'h4E, 1'b0, 1'b0);
      rdchk("R4", 4'h6, 8'h06);

      // R9 software reset
      wr(4'h6, 8'h47, 1'b1, 1'b0);
      chk("R9", {7'd0, rst_req}, 8'h01);
      rdchk("R9", 4'h5, 8'h00);
      rdchk("R9", 4'h6, 8'h06);
      wr(4'h6, 8'h41, 1'b0, 1'b0);
      chk("R7", {7'd0, rst_req}, 8'h00);

      // R6 no request when reset enable is clear
      wr(4'h6, 8'h44, 1'b1, 1'b0);
      wr(4'h3, 8'hFF, 1'b0, 1'b0);
      tick_n(1);
      chk("R6", {7'd0, rst_req}, 8'h00);
      chk("R5", {7'd0, irq}, 8'h01);
      rdchk("R6", 4'h5, 8'h00);
      rdchk("R3", 4'h6, 8'h0C);

      // R10 pin cause and priorities
      pin_rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pin_rst = 1'b0;
      rdchk("R10", 4'h5, 8'h03);
      wr(4'h6, 8'h4A, 1'b1, 1'b0);
      rdchk("R10", 4'h6, 8'h02);
      wr(4'h3, 8'hFF, 1'b0, 1'b0);
      wr(4'h6, 8'h4E, 1'b0, 1'b0);
      pin_rst = 1'b1; tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      pin_rst = 1'b0; tick = 1'b0;
      chk("R10", {7'd0, rst_req}, 8'h01);
      rdchk("R10", 4'h5, 8'h03);
      wr(4'h3, 8'hFF, 1'b0, 1'b0);
      wr(4'h6, 8'h43, 1'b1, 1'b1);
      chk("R10", {7'd0, rst_req}, 8'h01);
      rdchk("R10", 4'h5, 8'h02);

      // R11 system reset keeps cause, power-on clears it
      sys_rst_n = 1'b0;
      @(negedge clk);
      sys_rst_n = 1'b1;
      @(negedge clk);
      rdchk("R11", 4'h3, 8'h00);
      rdchk("R11", 4'h6, 8'h00);
      rdchk("R11", 4'h5, 8'h02);
      chk("R11", {7'd0, irq}, 8'h00);
      por_n = 1'b0; sys_rst_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1; sys_rst_n = 1'b1;
      @(negedge clk);
      rdchk("R11", 4'h5, 8'h01);
      chk("R1", {7'd0, rst_req}, 8'h00);

      finish_run();
   end

endmodule